// File: doc/BRIEF.md
# Serial Flash Geometry Probe

This block runs once after reset and works out the layout of a page-organised serial flash on the bus. It drives a byte-wide full-duplex transfer port and leaves bit-level serialisation to a separate SPI engine. Each byte request carries the byte to send and a flag that closes the chip-select frame after that byte. The engine answers with a one-cycle acknowledge and the byte it received. The probe first asks the part for its standard three-byte identification. If the part is not from the expected vendor, the probe falls back to reading the status byte, which on older parts holds a 4-bit density code.

When the probe ends it pulses either a done strobe or a no-device strobe for one cycle. From that point it holds four values on registered outputs:

- the page count,
- the page size in bytes,
- the left shift that places a page number in a flash address,
- a flag telling whether the part carries one-time-programmable security bytes.

A two-bit cause code explains a no-device outcome. Software or a boot sequencer reads these values and needs no knowledge of the part.

For parts that offer both a power-of-two page size and an extended one, the choice depends on the current configuration of the part. The probe reads it from bit 0 of the status byte.

Top module: `flash_probe`

## Requirements
- R1: After reset the first frame is four bytes: opcode 0x9F, then three fill bytes of 0x00 whose replies are the manufacturer byte, the device-ID high byte and the device-ID low byte, in that order. Every byte sent after an opcode is 0x00.
- R2: If the manufacturer byte is not 0x1F, the probe sends one two-byte status frame (opcode 0xD7, then a fill byte) and decodes the reply as a legacy part. On this path `otp_cap` ends at 0.
- R3: On the legacy path, a status reply of 0x00 or 0xFF ends the probe with `probe_nodev` and `fail_code` = 1 (absent).
- R4: On the legacy path the code is status bits 5:2. Bits 7, 6, 1 and 0 have no effect on the result. The codes map as follows (pages, page bytes, shift):
  - 3 → 512, 264, 9
  - 5 → 1024, 264, 9
  - 7 → 2048, 264, 9
  - 9 → 4096, 264, 9
  - 11 → 4096, 528, 10
  - 13 → 8192, 528, 10
- R5: Legacy codes 14 and 15 both give 8192 pages of 1056 bytes with shift 11. Every other legacy code ends with `probe_nodev` and `fail_code` = 3 (unsupported).
- R6: With vendor 0x1F and a known device ID that has a dual page size, the probe sends one status frame and uses bit 0 of the reply. Bit 0 set selects the power-of-two size (bytes = 2^(shift−1) of the extended entry, shift one lower). Bit 0 clear selects the extended size. The known IDs (high byte, low byte) and their extended geometry are:
  - 0x22,0x00 → 512 pages, 264 bytes, shift 9
  - 0x23,0x00 → 1024 pages, 264 bytes, shift 9
  - 0x24,0x00 → 2048 pages, 264 bytes, shift 9
  - 0x25,0x00 → 4096 pages, 264 bytes, shift 9
  - 0x26,0x00 → 4096 pages, 528 bytes, shift 10
  - 0x27,0x01 → 8192 pages, 528 bytes, shift 10
  - 0x28,0x00 → 8192 pages, 1056 bytes, shift 11
- R7: Device ID 0x27,0x00 gives 8192 pages of 528 bytes with shift 10. No status frame is sent for it.
- R8: Every matched identification sets `otp_cap` = 1. Vendor 0x1F with any other device ID ends with `probe_nodev` and `fail_code` = 2 (unknown). No status frame is sent in that case.
- R9: Exactly one of `probe_done` or `probe_nodev` is high, for exactly one cycle, per reset. The geometry, `otp_cap` and `fail_code` are valid in that cycle and stay unchanged afterwards. No further transfer is requested.
- R10: While reset is held and until the probe ends, `probe_done` and `probe_nodev` are 0. During reset the geometry outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_req | output | 1 | Byte transfer request, held until acknowledged |
| xfer_tx | output | 8 | Byte to send |
| xfer_last | output | 1 | Close chip-select after this byte |
| xfer_ack | input | 1 | One-cycle completion of the requested byte |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| probe_done | output | 1 | One-cycle pulse: geometry resolved |
| probe_nodev | output | 1 | One-cycle pulse: no usable device |
| fail_code | output | 2 | 0 none, 1 absent, 2 unknown ID, 3 unsupported legacy code |
| page_count | output | 14 | Number of pages |
| page_bytes | output | 11 | Bytes per page |
| page_shift | output | 4 | Page-number shift in a flash address |
| otp_cap | output | 1 | Part has one-time-programmable security bytes |

## Verification
The bench sweeps all 256 legacy status values. This catches several kinds of fault:

- a decode that looks at the wrong bits or lets bits 7, 6, 1 or 0 leak in returns wrong geometry;
- a missed 0x00/0xFF check decodes a floating bus as a part;
- a design that drops the shared mapping of codes 14 and 15 flags a valid part as unsupported.

On the identification path it crosses device-ID high bytes 0x21 to 0x29 with low bytes 0 to 2 and both polarities of status bit 0. That exposes an inverted page-size selection, a rev-C ID that wrongly triggers a status frame, and an unknown ID that gets a geometry. Frame counts, frame lengths and opcodes are recorded for every run. A few cycles after each finish the bench checks that the pulse has dropped, the outputs are stable and no further frame has started.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam int PAGES_W = 14;
  localparam int BYTES_W = 11;
  localparam int SHIFT_W = 4;

  typedef struct packed {
    logic [PAGES_W-1:0] pages;
    logic [BYTES_W-1:0] bytes;
    logic [SHIFT_W-1:0] shift;
  } geom_t;

  typedef enum logic [1:0] {
    FAIL_NONE    = 2'd0,
    FAIL_ABSENT  = 2'd1,
    FAIL_UNKNOWN = 2'd2,
    FAIL_UNSUPP  = 2'd3
  } fail_e;

  function automatic geom_t mk_geom(input int unsigned pg, input int unsigned by,
                                    input int unsigned sh);
    geom_t g;
    g.pages = PAGES_W'(pg);
    g.bytes = BYTES_W'(by);
    g.shift = SHIFT_W'(sh);
    return g;
  endfunction

endpackage

// File: rtl/flash_probe_id_lut.sv
module flash_probe_id_lut
  import flash_probe_pkg::*;
(
  input  logic [15:0] dev_id,
  output logic        hit,
  output logic        dual_size,
  output geom_t       geom_ext,
  output geom_t       geom_bin
);

  always_comb begin
    hit       = 1'b1;
    dual_size = 1'b1;
    geom_ext  = '0;
    unique case (dev_id)
      16'h2200: geom_ext = mk_geom(512,  264,  9);
      16'h2300: geom_ext = mk_geom(1024, 264,  9);
      16'h2400: geom_ext = mk_geom(2048, 264,  9);
      16'h2500: geom_ext = mk_geom(4096, 264,  9);
      16'h2600: geom_ext = mk_geom(4096, 528,  10);
      16'h2700: begin
        geom_ext  = mk_geom(8192, 528, 10);
        dual_size = 1'b0;
      end
      16'h2701: geom_ext = mk_geom(8192, 528,  10);
      16'h2800: geom_ext = mk_geom(8192, 1056, 11);
      default: begin
        hit       = 1'b0;
        dual_size = 1'b0;
      end
    endcase
  end

  // Binary variant: one shift step smaller, bytes equal to 2^shift.
  always_comb begin
    geom_bin       = geom_ext;
    geom_bin.shift = geom_ext.shift - SHIFT_W'(1);
    geom_bin.bytes = BYTES_W'(1) << geom_bin.shift;
  end

endmodule

// File: rtl/flash_probe_legacy_lut.sv
module flash_probe_legacy_lut
  import flash_probe_pkg::*;
(
  input  logic [3:0] code,
  output logic       valid,
  output geom_t      geom
);

  always_comb begin
    valid = 1'b1;
    geom  = '0;
    unique case (code)
      4'd3:  geom = mk_geom(512,  264,  9);
      4'd5:  geom = mk_geom(1024, 264,  9);
      4'd7:  geom = mk_geom(2048, 264,  9);
      4'd9:  geom = mk_geom(4096, 264,  9);
      4'd11: geom = mk_geom(4096, 528,  10);
      4'd13: geom = mk_geom(8192, 528,  10);
      4'd14,
      4'd15: geom = mk_geom(8192, 1056, 11);
      default: valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
  import flash_probe_pkg::*;
#(
  parameter logic [7:0] OP_IDENT  = 8'h9F,
  parameter logic [7:0] OP_STATUS = 8'hD7,
  parameter logic [7:0] VENDOR    = 8'h1F
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        xfer_req,
  output logic [7:0]  xfer_tx,
  output logic        xfer_last,
  input  logic        xfer_ack,
  input  logic [7:0]  xfer_rx,
  output logic [15:0] dev_id,
  output logic [7:0]  status,
  input  logic        id_hit,
  input  logic        id_dual,
  input  geom_t       id_geom_ext,
  input  geom_t       id_geom_bin,
  input  logic        leg_valid,
  input  geom_t       leg_geom,
  output logic        done,
  output logic        nodev,
  output logic [1:0]  fail_code,
  output geom_t       geom,
  output logic        otp
);

  typedef enum logic [3:0] {
    S_START, S_ID_OP, S_ID_MF, S_ID_HI, S_ID_LO, S_ID_EVAL,
    S_ST_OP, S_ST_RD, S_ST_EVAL, S_HALT
  } state_e;

  state_e      state_q, state_d;
  logic [7:0]  mfr_q, mfr_d;
  logic [15:0] dev_q, dev_d;
  logic [7:0]  stat_q, stat_d;
  logic        legacy_q, legacy_d;
  geom_t       geom_q, geom_d;
  logic        otp_q, otp_d;
  fail_e       fail_q, fail_d;
  logic        done_q, done_d;
  logic        nodev_q, nodev_d;

  // Transfer port driven from state
  always_comb begin
    xfer_req  = 1'b0;
    xfer_tx   = 8'h00;
    xfer_last = 1'b0;
    unique case (state_q)
      S_ID_OP: begin xfer_req = 1'b1; xfer_tx = OP_IDENT;  end
      S_ST_OP: begin xfer_req = 1'b1; xfer_tx = OP_STATUS; end
      S_ID_MF, S_ID_HI: xfer_req = 1'b1;
      S_ID_LO, S_ST_RD: begin xfer_req = 1'b1; xfer_last = 1'b1; end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    mfr_d    = mfr_q;
    dev_d    = dev_q;
    stat_d   = stat_q;
    legacy_d = legacy_q;
    geom_d   = geom_q;
    otp_d    = otp_q;
    fail_d   = fail_q;
    done_d   = 1'b0;
    nodev_d  = 1'b0;
    unique case (state_q)
      S_START: state_d = S_ID_OP;
      S_ID_OP: if (xfer_ack) state_d = S_ID_MF;
      S_ID_MF: if (xfer_ack) begin
        mfr_d   = xfer_rx;
        state_d = S_ID_HI;
      end
      S_ID_HI: if (xfer_ack) begin
        dev_d[15:8] = xfer_rx;
        state_d     = S_ID_LO;
      end
      S_ID_LO: if (xfer_ack) begin
        dev_d[7:0] = xfer_rx;
        state_d    = S_ID_EVAL;
      end
      S_ID_EVAL: begin
        if (mfr_q != VENDOR) begin
          legacy_d = 1'b1;
          state_d  = S_ST_OP;
        end else if (!id_hit) begin
          fail_d  = FAIL_UNKNOWN;
          nodev_d = 1'b1;
          state_d = S_HALT;
        end else if (id_dual) begin
          state_d = S_ST_OP;
        end else begin
          geom_d  = id_geom_ext;
          otp_d   = 1'b1;
          done_d  = 1'b1;
          state_d = S_HALT;
        end
      end
      S_ST_OP: if (xfer_ack) state_d = S_ST_RD;
      S_ST_RD: if (xfer_ack) begin
        stat_d  = xfer_rx;
        state_d = S_ST_EVAL;
      end
      S_ST_EVAL: begin
        state_d = S_HALT;
        if (legacy_q) begin
          if (stat_q == 8'h00 || stat_q == 8'hFF) begin
            fail_d  = FAIL_ABSENT;
            nodev_d = 1'b1;
          end else if (leg_valid) begin
            geom_d = leg_geom;
            otp_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            fail_d  = FAIL_UNSUPP;
            nodev_d = 1'b1;
          end
        end else begin
          geom_d = stat_q[0] ? id_geom_bin : id_geom_ext;
          otp_d  = 1'b1;
          done_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_START;
      mfr_q    <= '0;
      dev_q    <= '0;
      stat_q   <= '0;
      legacy_q <= 1'b0;
      geom_q   <= '0;
      otp_q    <= 1'b0;
      fail_q   <= FAIL_NONE;
      done_q   <= 1'b0;
      nodev_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      mfr_q    <= mfr_d;
      dev_q    <= dev_d;
      stat_q   <= stat_d;
      legacy_q <= legacy_d;
      geom_q   <= geom_d;
      otp_q    <= otp_d;
      fail_q   <= fail_d;
      done_q   <= done_d;
      nodev_q  <= nodev_d;
    end
  end

  assign dev_id    = dev_q;
  assign status    = stat_q;
  assign done      = done_q;
  assign nodev     = nodev_q;
  assign fail_code = fail_q;
  assign geom      = geom_q;
  assign otp       = otp_q;

  // R9: the two end strobes never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && nodev_q));

  // R9: an end strobe lasts one cycle
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || nodev_q) |=> !(done_q || nodev_q));

  // R9: results stay frozen after the probe ends
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HALT) |=> ($stable(geom_q) && $stable(otp_q) && $stable(fail_q)));

  // R2: a legacy result never claims OTP support
  a_r2_legacy_no_otp: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && legacy_q) |-> !otp_q);

  // R8: unknown-ID failure only arises off the legacy path
  a_r8_unknown_not_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (nodev_q && fail_q == FAIL_UNKNOWN) |-> !legacy_q);

  // R10: strobes only fire once the sequence has finished
  a_r10_strobe_state: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || nodev_q) |-> (state_q == S_HALT));

endmodule

// File: rtl/flash_probe.sv
module flash_probe
  import flash_probe_pkg::*;
#(
  parameter logic [7:0] OP_IDENT  = 8'h9F,
  parameter logic [7:0] OP_STATUS = 8'hD7,
  parameter logic [7:0] VENDOR    = 8'h1F,
  parameter int         SYNC_LEN  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               xfer_req,
  output logic [7:0]         xfer_tx,
  output logic               xfer_last,
  input  logic               xfer_ack,
  input  logic [7:0]         xfer_rx,
  output logic               probe_done,
  output logic               probe_nodev,
  output logic [1:0]         fail_code,
  output logic [PAGES_W-1:0] page_count,
  output logic [BYTES_W-1:0] page_bytes,
  output logic [SHIFT_W-1:0] page_shift,
  output logic               otp_cap
);

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[SYNC_LEN-1];

  logic [15:0] dev_id;
  logic [7:0]  status;
  logic        id_hit, id_dual, leg_valid;
  geom_t       id_geom_ext, id_geom_bin, leg_geom, geom;

  flash_probe_id_lut u_id_lut (
    .dev_id    (dev_id),
    .hit       (id_hit),
    .dual_size (id_dual),
    .geom_ext  (id_geom_ext),
    .geom_bin  (id_geom_bin)
  );

  flash_probe_legacy_lut u_leg_lut (
    .code  (status[5:2]),
    .valid (leg_valid),
    .geom  (leg_geom)
  );

  flash_probe_seq #(
    .OP_IDENT  (OP_IDENT),
    .OP_STATUS (OP_STATUS),
    .VENDOR    (VENDOR)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .xfer_req    (xfer_req),
    .xfer_tx     (xfer_tx),
    .xfer_last   (xfer_last),
    .xfer_ack    (xfer_ack),
    .xfer_rx     (xfer_rx),
    .dev_id      (dev_id),
    .status      (status),
    .id_hit      (id_hit),
    .id_dual     (id_dual),
    .id_geom_ext (id_geom_ext),
    .id_geom_bin (id_geom_bin),
    .leg_valid   (leg_valid),
    .leg_geom    (leg_geom),
    .done        (probe_done),
    .nodev       (probe_nodev),
    .fail_code   (fail_code),
    .geom        (geom),
    .otp         (otp_cap)
  );

  assign page_count = geom.pages;
  assign page_bytes = geom.bytes;
  assign page_shift = geom.shift;

  // R10: nothing is requested before the synchronised reset lifts
  a_r10_no_req_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s_n |-> !xfer_req);

endmodule

// File: tb/tb_flash_probe.sv
module tb_flash_probe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_req, xfer_last;
  logic [7:0]  xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;
  logic        probe_done, probe_nodev, otp_cap;
  logic [1:0]  fail_code;
  logic [13:0] page_count;
  logic [10:0] page_bytes;
  logic [3:0]  page_shift;

  always #2 clk = ~clk;

  flash_probe dut (
    .clk(clk), .rst_n(rst_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .probe_done(probe_done), .probe_nodev(probe_nodev), .fail_code(fail_code),
    .page_count(page_count), .page_bytes(page_bytes), .page_shift(page_shift),
    .otp_cap(otp_cap)
  );

  int checks = 0, failures = 0;

  // Flash model state
  logic [7:0] m_mfr, m_hi, m_lo, m_stat;
  int         nframes, fidx, fill_bad;
  logic [7:0] cur_op;
  logic [7:0] ops  [4];
  int         flen [4];

  initial begin
    m_mfr = 0; m_hi = 0; m_lo = 0; m_stat = 0;
    nframes = 0; fidx = 0; fill_bad = 0; cur_op = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        xfer_ack = 1'b0; nframes = 0; fidx = 0; fill_bad = 0;
        for (int i = 0; i < 4; i++) begin ops[i] = 8'h00; flen[i] = 0; end
      end else if (xfer_ack) begin
        xfer_ack = 1'b0;
      end else if (xfer_req) begin
        if (fidx == 0) begin
          cur_op = xfer_tx;
          if (nframes < 4) ops[nframes] = xfer_tx;
          xfer_rx = 8'h00;
        end else begin
          if (xfer_tx != 8'h00) fill_bad = 1;
          if (cur_op == 8'h9F)
            xfer_rx = (fidx == 1) ? m_mfr : (fidx == 2) ? m_hi : (fidx == 3) ? m_lo : 8'h00;
          else if (cur_op == 8'hD7)
            xfer_rx = (fidx == 1) ? m_stat : 8'h00;
          else
            xfer_rx = 8'h00;
        end
        fidx++;
        if (xfer_last) begin
          if (nframes < 4) flen[nframes] = fidx;
          nframes++;
          fidx = 0;
        end
        xfer_ack = 1'b1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=end");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // Expected geometry
  int e_ok, e_fail, e_pages, e_bytes, e_shift, e_otp, e_frames;

  function automatic void exp_legacy(input logic [7:0] s);
    int c;
    c = int'(s[5:2]);
    e_otp = 0; e_frames = 2; e_ok = 1; e_fail = 0;
    if (s == 8'h00 || s == 8'hFF) begin e_ok = 0; e_fail = 1; end
    else if (c == 3 || c == 5 || c == 7 || c == 9) begin
      e_pages = 512 << ((c - 3) / 2); e_bytes = 264; e_shift = 9;
    end else if (c == 11) begin e_pages = 4096; e_bytes = 528; e_shift = 10; end
    else if (c == 13) begin e_pages = 8192; e_bytes = 528; e_shift = 10; end
    else if (c >= 14) begin e_pages = 8192; e_bytes = 1056; e_shift = 11; end
    else begin e_ok = 0; e_fail = 3; end
  endfunction

  function automatic void exp_ident(input logic [7:0] hi, input logic [7:0] lo,
                                    input logic [7:0] s);
    int d; bit hit, dual;
    d    = int'(hi) - 'h22;
    hit  = (d >= 0 && d <= 6 && lo == 8'h00) || (hi == 8'h27 && lo == 8'h01);
    dual = hit && !(hi == 8'h27 && lo == 8'h00);
    e_otp = 1; e_ok = hit; e_fail = hit ? 0 : 2; e_frames = dual ? 2 : 1;
    if (hit) begin
      e_pages = (d <= 3) ? (512 << d) : (d == 4) ? 4096 : 8192;
      e_bytes = (d <= 3) ? 264 : (d <= 5) ? 528 : 1056;
      e_shift = (d <= 3) ? 9 : (d <= 5) ? 10 : 11;
      if (dual && s[0]) begin
        e_shift = e_shift - 1;
        e_bytes = 1 << e_shift;
      end
    end
  endfunction

  task automatic run(input logic [7:0] mf, input logic [7:0] hi, input logic [7:0] lo,
                     input logic [7:0] s, input bit first);
    int cyc;
    int p_pages, p_bytes, p_shift, p_frames;
    bit legacy;
    legacy = (mf != 8'h1F);
    @(negedge clk);
    rst_n = 1'b0;
    m_mfr = mf; m_hi = hi; m_lo = lo; m_stat = s;
    repeat (2) @(negedge clk);
    if (first) begin
      chk(probe_done == 0 && probe_nodev == 0, "R10 strobes in reset", int'(probe_done), 0);
      chk(page_count == 0 && page_bytes == 0, "R10 geometry in reset", int'(page_count), 0);
    end
    rst_n = 1'b1;
    cyc = 0;
    while (!(probe_done || probe_nodev) && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    if (legacy) exp_legacy(s); else exp_ident(hi, lo, s);
    chk(ops[0] == 8'h9F && flen[0] == 4, "R1 ident frame", int'(ops[0]), 'h9F);
    chk(fill_bad == 0, "R1 fill bytes zero", fill_bad, 0);
    chk(nframes == e_frames, legacy ? "R2 frame count" : (e_ok ? "R6/R7 frame count" : "R8 frame count"),
        nframes, e_frames);
    if (e_frames == 2)
      chk(ops[1] == 8'hD7 && flen[1] == 2, "R2/R6 status frame", int'(ops[1]), 'hD7);
    if (e_ok) begin
      chk(probe_done == 1 && probe_nodev == 0, legacy ? "R4 done" : "R6 done", int'(probe_done), 1);
      chk(int'(page_count) == e_pages, legacy ? "R4 pages" : "R6 pages", int'(page_count), e_pages);
      chk(int'(page_bytes) == e_bytes, legacy ? "R5 bytes" : "R6 bytes", int'(page_bytes), e_bytes);
      chk(int'(page_shift) == e_shift, legacy ? "R4 shift" : "R7 shift", int'(page_shift), e_shift);
      chk(int'(otp_cap) == e_otp, legacy ? "R2 otp" : "R8 otp", int'(otp_cap), e_otp);
    end else begin
      chk(probe_nodev == 1 && probe_done == 0, "R3/R5/R8 nodev", int'(probe_nodev), 1);
      chk(int'(fail_code) == e_fail, "R3/R5/R8 fail code", int'(fail_code), e_fail);
    end
    p_pages = int'(page_count); p_bytes = int'(page_bytes);
    p_shift = int'(page_shift); p_frames = nframes;
    repeat (3) @(negedge clk);
    chk(probe_done == 0 && probe_nodev == 0, "R9 single pulse", int'(probe_done | probe_nodev), 0);
    chk(int'(page_count) == p_pages && int'(page_bytes) == p_bytes && int'(page_shift) == p_shift,
        "R9 geometry held", int'(page_count), p_pages);
    chk(nframes == p_frames && xfer_req == 0, "R9 no further transfer", nframes, p_frames);
  endtask

  initial begin
    // Legacy path: every status byte (R2 R3 R4 R5)
    for (int s = 0; s < 256; s++)
      run(8'hFF, 8'h00, 8'h00, 8'(s), s == 0);
    // Legacy path with other non-vendor manufacturer codes
    run(8'h00, 8'h26, 8'h00, 8'h2C, 0);
    run(8'h1E, 8'h22, 8'h00, 8'hBD, 0);
    // Identification path (R6 R7 R8)
    for (int h = 'h21; h <= 'h29; h++)
      for (int l = 0; l < 3; l++) begin
        run(8'h1F, 8'(h), 8'(l), 8'h80, 0);
        run(8'h1F, 8'(h), 8'(l), 8'h81, 0);
        run(8'h1F, 8'(h), 8'(l), 8'h3C, 0);
        run(8'h1F, 8'(h), 8'(l), 8'h3D, 0);
      end
    run(8'h1F, 8'h30, 8'h00, 8'h81, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule